// File: doc/BRIEF.md
# Control-Endpoint Setup Request Stall Decoder

This block sits behind the control endpoint of a device-side USB controller. When a setup packet has been latched, a one-cycle strobe presents its five fields (request type, request code, value, index, length). The block then decides how endpoint 0 responds: it can acknowledge with a status handshake, enter an IN or OUT data stage, or force a stall. For endpoint halt requests it also raises set or clear strobes and updates a halt flag for each bulk endpoint.

The policy for feature and interface requests is fixed in hardware. Any other standard request, and every class, vendor or reserved request, goes to a handler that is gated by an enable input. When that enable is low, the request stalls.

A matching SET_INTERFACE request is answered with an empty success. The setup fields enter as a plain strobed word that is consumed in the strobe cycle and never back-pressured, because the packet buffer upstream holds them stable. Every result is a registered pulse or level, so no output depends combinationally on an input.

Top module: `setup_stall_decoder`

## Requirements
- R1: A SET_FEATURE request (code 3) whose recipient (request type bits 4:0) is the device (0) always stalls.
- R2: A SET_FEATURE (code 3) or CLEAR_FEATURE (code 1) request whose recipient is an endpoint (2) stalls in any of these cases: the length is nonzero, the low value byte is not the halt selector 0, or `cfg_done` is low.
- R3: An otherwise valid endpoint halt request with low index byte 0x01 sets or clears halt bit 0; with 0x82 it sets or clears halt bit 1. The matching `halt_set`/`halt_clr` bit pulses, and `halt_q` shows the new value in the same cycle.
- R4: An endpoint halt request with any other low index byte stalls, with no halt strobe and no change to `halt_q`.
- R5: SET_INTERFACE (code 11) is acknowledged when all of the following hold: the length is zero, the high bytes of value and index are zero, `cfg_done` is high, the low index byte equals parameter IFACE_NUM, and the low value byte equals ALT_NUM. Otherwise it stalls.
- R6: Request type bits 6:5 select the kind: 0 standard, 1 class, 2 vendor, 3 reserved. A class, vendor or reserved request is handled only if `class_en`, `vendor_en` or `rsvd_en` respectively is high. A standard request not covered by R1, R2 and R5 is handled only if `std_en` is high. An unhandled request stalls.
- R7: For an unhandled request, `stall_p`, `svc_p` and `dend_p` pulse together, and no data stage is entered.
- R8: A handled request with zero length pulses `svc_p` and `dend_p` without `stall_p`, and leaves no data stage active.
- R9: A handled request with nonzero length pulses `svc_p` without `dend_p`. It sets `stage_act`, and `stage_in` follows type bit 7 (1 = IN). The stage ends on `stage_done` or on the next setup strobe.
- R10: Each `setup_vld` strobe produces exactly one `svc_p`. `svc_p`, `stall_p`, `dend_p`, `halt_set` and `halt_clr` are high for exactly the one cycle after the strobe's clock edge.
- R11: Reset clears every halt flag, ends any data stage and drops all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_vld | input | 1 | One-cycle strobe: setup fields are valid |
| rq_type | input | 8 | Request type byte (direction, kind, recipient) |
| rq_code | input | 8 | Request code |
| rq_value | input | 16 | Value field |
| rq_index | input | 16 | Index field |
| rq_len | input | 16 | Length field |
| cfg_done | input | 1 | Device is in the configured state |
| std_en | input | 1 | Fallback handler accepts other standard requests |
| class_en | input | 1 | Class handler enabled |
| vendor_en | input | 1 | Vendor handler enabled |
| rsvd_en | input | 1 | Reserved-kind handler enabled |
| stage_done | input | 1 | Data stage finished |
| svc_p | output | 1 | Setup serviced pulse |
| stall_p | output | 1 | Force-stall pulse |
| dend_p | output | 1 | Data-end pulse |
| halt_set | output | NUM_EP | Per-endpoint halt set strobes |
| halt_clr | output | NUM_EP | Per-endpoint halt clear strobes |
| halt_q | output | NUM_EP | Per-endpoint halt flags |
| stage_act | output | 1 | Data stage in progress |
| stage_in | output | 1 | Data stage direction is IN |

## Verification
Every response is registered once. The pulses, the halt flags and the data-stage level therefore all appear in the cycle that directly follows the clock edge at which `setup_vld` is sampled, and the pulses are gone one cycle later. The bench drives each strobe on a falling edge and samples all outputs on the next falling edge, where the results are due. It samples once more a cycle later to confirm that the pulses have dropped and the halt flags have held. For `stage_done`, the same one-cycle spacing is used to see `stage_act` fall.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

  localparam logic [7:0] CODE_CLR_FEAT = 8'd1;
  localparam logic [7:0] CODE_SET_FEAT = 8'd3;
  localparam logic [7:0] CODE_SET_IF   = 8'd11;
  localparam logic [7:0] SEL_HALT      = 8'd0;
  localparam logic [4:0] RCP_DEVICE    = 5'd0;
  localparam logic [4:0] RCP_ENDPOINT  = 5'd2;

  typedef enum logic [1:0] {
    KIND_STD    = 2'd0,
    KIND_CLASS  = 2'd1,
    KIND_VENDOR = 2'd2,
    KIND_RSVD   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_IN   = 2'd1,
    PH_OUT  = 2'd2
  } stage_e;

  typedef struct packed {
    logic [7:0]  rtype;
    logic [7:0]  code;
    logic [15:0] value;
    logic [15:0] index;
    logic [15:0] len;
  } setup_t;

endpackage

// File: rtl/ssd_classify.sv
module ssd_classify
  import ssd_pkg::*;
(
  input  setup_t    pkt,
  output req_kind_e kind,
  output logic      rcp_dev,
  output logic      rcp_ep,
  output logic      dir_in,
  output logic      len_zero
);
  always_comb begin
    kind     = req_kind_e'(pkt.rtype[6:5]);
    rcp_dev  = (pkt.rtype[4:0] == RCP_DEVICE);
    rcp_ep   = (pkt.rtype[4:0] == RCP_ENDPOINT);
    dir_in   = pkt.rtype[7];
    len_zero = (pkt.len == 16'd0);
  end
endmodule

// File: rtl/ssd_std_policy.sv
module ssd_std_policy
  import ssd_pkg::*;
#(
  parameter int unsigned NUM_EP = 2,
  parameter logic [NUM_EP*8-1:0] EP_ADDRS = 16'h8201,
  parameter logic [7:0] IFACE_NUM = 8'd0,
  parameter logic [7:0] ALT_NUM = 8'd0
) (
  input  setup_t            pkt,
  input  logic              rcp_dev,
  input  logic              rcp_ep,
  input  logic              len_zero,
  input  logic              cfg_done,
  output logic              fixed,
  output logic              fixed_ok,
  output logic [NUM_EP-1:0] set_vec,
  output logic [NUM_EP-1:0] clr_vec
);
  logic              is_setf, is_clrf, is_setif;
  logic              dev_setf, ep_feat, feat_ok, if_ok;
  logic [NUM_EP-1:0] hit;

  for (genvar k = 0; k < NUM_EP; k++) begin : g_hit
    assign hit[k] = (pkt.index[7:0] == EP_ADDRS[k*8 +: 8]);
  end

  always_comb begin
    is_setf  = (pkt.code == CODE_SET_FEAT);
    is_clrf  = (pkt.code == CODE_CLR_FEAT);
    is_setif = (pkt.code == CODE_SET_IF);
    dev_setf = is_setf && rcp_dev;
    ep_feat  = (is_setf || is_clrf) && rcp_ep;
    feat_ok  = len_zero && (pkt.value[7:0] == SEL_HALT) && cfg_done && (|hit);
    if_ok    = len_zero && (pkt.value[15:8] == 8'd0) && (pkt.index[15:8] == 8'd0)
               && cfg_done && (pkt.index[7:0] == IFACE_NUM) && (pkt.value[7:0] == ALT_NUM);
    fixed    = dev_setf || ep_feat || is_setif;
    if (dev_setf)     fixed_ok = 1'b0;
    else if (ep_feat) fixed_ok = feat_ok;
    else              fixed_ok = if_ok;
    set_vec  = hit & {NUM_EP{ep_feat && feat_ok && is_setf}};
    clr_vec  = hit & {NUM_EP{ep_feat && feat_ok && is_clrf}};
  end
endmodule

// File: rtl/ssd_halt_bank.sv
module ssd_halt_bank #(
  parameter int unsigned NUM_EP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] set_v,
  input  logic [NUM_EP-1:0] clr_v,
  output logic [NUM_EP-1:0] halt_q
);
  for (genvar k = 0; k < NUM_EP; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        halt_q[k] <= 1'b0;
      else if (set_v[k]) halt_q[k] <= 1'b1;
      else if (clr_v[k]) halt_q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/setup_stall_decoder.sv
module setup_stall_decoder
  import ssd_pkg::*;
#(
  parameter int unsigned NUM_EP = 2,
  parameter logic [NUM_EP*8-1:0] EP_ADDRS = 16'h8201,
  parameter logic [7:0] IFACE_NUM = 8'd0,
  parameter logic [7:0] ALT_NUM = 8'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_vld,
  input  logic [7:0]        rq_type,
  input  logic [7:0]        rq_code,
  input  logic [15:0]       rq_value,
  input  logic [15:0]       rq_index,
  input  logic [15:0]       rq_len,
  input  logic              cfg_done,
  input  logic              std_en,
  input  logic              class_en,
  input  logic              vendor_en,
  input  logic              rsvd_en,
  input  logic              stage_done,
  output logic              svc_p,
  output logic              stall_p,
  output logic              dend_p,
  output logic [NUM_EP-1:0] halt_set,
  output logic [NUM_EP-1:0] halt_clr,
  output logic [NUM_EP-1:0] halt_q,
  output logic              stage_act,
  output logic              stage_in
);
  setup_t            pkt;
  req_kind_e         kind;
  logic              rcp_dev, rcp_ep, dir_in, len_zero;
  logic              fixed, fixed_ok, handled;
  logic [NUM_EP-1:0] set_vec, clr_vec, set_go, clr_go;
  stage_e            stage_q, stage_d;

  assign pkt = '{rtype: rq_type, code: rq_code, value: rq_value,
                 index: rq_index, len: rq_len};

  ssd_classify u_cls (
    .pkt(pkt), .kind(kind), .rcp_dev(rcp_dev), .rcp_ep(rcp_ep),
    .dir_in(dir_in), .len_zero(len_zero)
  );

  ssd_std_policy #(
    .NUM_EP(NUM_EP), .EP_ADDRS(EP_ADDRS), .IFACE_NUM(IFACE_NUM), .ALT_NUM(ALT_NUM)
  ) u_pol (
    .pkt(pkt), .rcp_dev(rcp_dev), .rcp_ep(rcp_ep), .len_zero(len_zero),
    .cfg_done(cfg_done), .fixed(fixed), .fixed_ok(fixed_ok),
    .set_vec(set_vec), .clr_vec(clr_vec)
  );

  always_comb begin
    unique case (kind)
      KIND_STD:    handled = fixed ? fixed_ok : std_en;
      KIND_CLASS:  handled = class_en;
      KIND_VENDOR: handled = vendor_en;
      default:     handled = rsvd_en;
    endcase
    set_go = set_vec & {NUM_EP{setup_vld && kind == KIND_STD}};
    clr_go = clr_vec & {NUM_EP{setup_vld && kind == KIND_STD}};
    stage_d = stage_q;
    if (setup_vld) begin
      if (handled && !len_zero) stage_d = dir_in ? PH_IN : PH_OUT;
      else                      stage_d = PH_IDLE;
    end else if (stage_done) begin
      stage_d = PH_IDLE;
    end
  end

  ssd_halt_bank #(.NUM_EP(NUM_EP)) u_halt (
    .clk(clk), .rst_n(rst_n), .set_v(set_go), .clr_v(clr_go), .halt_q(halt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_p    <= 1'b0;
      stall_p  <= 1'b0;
      dend_p   <= 1'b0;
      halt_set <= '0;
      halt_clr <= '0;
      stage_q  <= PH_IDLE;
    end else begin
      svc_p    <= setup_vld;
      stall_p  <= setup_vld && !handled;
      dend_p   <= setup_vld && (!handled || len_zero);
      halt_set <= set_go;
      halt_clr <= clr_go;
      stage_q  <= stage_d;
    end
  end

  assign stage_act = (stage_q != PH_IDLE);
  assign stage_in  = (stage_q == PH_IN);
endmodule

// File: rtl/setup_stall_decoder_chk.sv
module setup_stall_decoder_chk #(
  parameter int unsigned NUM_EP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              setup_vld,
  input logic              svc_p,
  input logic              stall_p,
  input logic              dend_p,
  input logic [NUM_EP-1:0] halt_set,
  input logic [NUM_EP-1:0] halt_clr,
  input logic [NUM_EP-1:0] halt_q,
  input logic              stage_act
);
  AST_SVC_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_p |-> $past(setup_vld)); // R10
  AST_STALL_WITH_DEND: assert property (@(posedge clk) disable iff (!rst_n)
    stall_p |-> (svc_p && dend_p && !stage_act)); // R7
  AST_HALT_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_set, halt_clr})); // R3
  AST_HALT_SET_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_set & ~halt_q) == '0)); // R3
  AST_HALT_CLR_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_clr & halt_q) == '0)); // R3
  AST_STALL_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    stall_p |-> (halt_set == '0 && halt_clr == '0)); // R4
  AST_DATA_STAGE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_p && !dend_p) |-> stage_act); // R9
  AST_HALT_STROBE_NEEDS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (|{halt_set, halt_clr}) |-> (svc_p && !stall_p)); // R10
endmodule

bind setup_stall_decoder setup_stall_decoder_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .svc_p(svc_p),
  .stall_p(stall_p), .dend_p(dend_p), .halt_set(halt_set),
  .halt_clr(halt_clr), .halt_q(halt_q), .stage_act(stage_act)
);

// File: tb/setup_stall_decoder_tb_top.sv
module setup_stall_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_vld = 1'b0;
  logic [7:0]  rq_type = '0, rq_code = '0;
  logic [15:0] rq_value = '0, rq_index = '0, rq_len = '0;
  logic        cfg_done = 1'b1, std_en = 1'b1, class_en = 1'b1;
  logic        vendor_en = 1'b1, rsvd_en = 1'b0, stage_done = 1'b0;
  logic        svc_p, stall_p, dend_p, stage_act, stage_in;
  logic [1:0]  halt_set, halt_clr, halt_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  setup_stall_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .rq_type(rq_type),
    .rq_code(rq_code), .rq_value(rq_value), .rq_index(rq_index), .rq_len(rq_len),
    .cfg_done(cfg_done), .std_en(std_en), .class_en(class_en),
    .vendor_en(vendor_en), .rsvd_en(rsvd_en), .stage_done(stage_done),
    .svc_p(svc_p), .stall_p(stall_p), .dend_p(dend_p), .halt_set(halt_set),
    .halt_clr(halt_clr), .halt_q(halt_q), .stage_act(stage_act), .stage_in(stage_in)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drive one setup, check the response one cycle later, then check the pulses drop.
  task automatic run_setup(input string tag, input logic [7:0] rt, input logic [7:0] code,
                           input logic [15:0] val, input logic [15:0] idx, input logic [15:0] len,
                           input bit e_stall, input bit e_dend, input logic [1:0] e_set,
                           input logic [1:0] e_clr, input bit e_act, input bit e_in,
                           input logic [1:0] e_halt);
    @(negedge clk);
    rq_type = rt; rq_code = code; rq_value = val; rq_index = idx; rq_len = len;
    setup_vld = 1'b1;
    @(negedge clk);
    setup_vld = 1'b0;
    chk({tag, " svc R10"}, 16'(svc_p), 16'd1);
    chk({tag, " stall"}, 16'(stall_p), 16'(e_stall));
    chk({tag, " dend"}, 16'(dend_p), 16'(e_dend));
    chk({tag, " halt_set"}, 16'(halt_set), 16'(e_set));
    chk({tag, " halt_clr"}, 16'(halt_clr), 16'(e_clr));
    chk({tag, " stage_act"}, 16'(stage_act), 16'(e_act));
    chk({tag, " stage_in"}, 16'(stage_in), 16'(e_in));
    chk({tag, " halt_q"}, 16'(halt_q), 16'(e_halt));
    @(negedge clk);
    chk({tag, " pulses drop R10"}, 16'({svc_p, stall_p, dend_p, halt_set, halt_clr}), 16'd0);
    chk({tag, " halt_q hold"}, 16'(halt_q), 16'(e_halt));
  endtask

  task automatic t_reset;
    chk("R11 reset halt_q", 16'(halt_q), 16'd0);
    chk("R11 reset pulses", 16'({svc_p, stall_p, dend_p, halt_set, halt_clr}), 16'd0);
    chk("R11 reset stage", 16'(stage_act), 16'd0);
  endtask

  task automatic t_device_feature;
    run_setup("R1 dev set_feature", 8'h00, 8'd3, 16'h0001, 16'h0000, 16'd0,
              1, 1, 2'b00, 2'b00, 0, 0, 2'b00);
  endtask

  task automatic t_halt_ops;
    run_setup("R3 set ep01", 8'h02, 8'd3, 16'h0000, 16'h0001, 16'd0, 0, 1, 2'b01, 2'b00, 0, 0, 2'b01);
    run_setup("R3 set ep82", 8'h02, 8'd3, 16'h0000, 16'h0082, 16'd0, 0, 1, 2'b10, 2'b00, 0, 0, 2'b11);
    run_setup("R3 clr ep01", 8'h02, 8'd1, 16'h0000, 16'h0001, 16'd0, 0, 1, 2'b00, 2'b01, 0, 0, 2'b10);
  endtask

  task automatic t_feature_stalls;
    run_setup("R2 len nonzero", 8'h02, 8'd3, 16'h0000, 16'h0001, 16'd2, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    run_setup("R2 bad selector", 8'h02, 8'd1, 16'h0001, 16'h0082, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    cfg_done = 1'b0;
    run_setup("R2 unconfigured", 8'h02, 8'd1, 16'h0000, 16'h0082, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    cfg_done = 1'b1;
    run_setup("R4 idx 81", 8'h02, 8'd3, 16'h0000, 16'h0081, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    run_setup("R4 idx 02", 8'h02, 8'd1, 16'h0000, 16'h0002, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
  endtask

  task automatic t_interface;
    run_setup("R5 match", 8'h01, 8'd11, 16'h0000, 16'h0000, 16'd0, 0, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    run_setup("R5 alt mismatch", 8'h01, 8'd11, 16'h0001, 16'h0000, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    run_setup("R5 value hi", 8'h01, 8'd11, 16'h0100, 16'h0000, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    run_setup("R5 index hi", 8'h01, 8'd11, 16'h0000, 16'h0100, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    cfg_done = 1'b0;
    run_setup("R5 unconfigured", 8'h01, 8'd11, 16'h0000, 16'h0000, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    cfg_done = 1'b1;
  endtask

  task automatic t_routing;
    run_setup("R6 R8 class on", 8'h21, 8'h0A, 16'h0000, 16'h0000, 16'd0, 0, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    class_en = 1'b0;
    run_setup("R6 R7 class off", 8'h21, 8'h0A, 16'h0000, 16'h0000, 16'd0, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    run_setup("R6 R7 reserved off", 8'h60, 8'h01, 16'h0000, 16'h0000, 16'd4, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    rsvd_en = 1'b1;
    run_setup("R6 reserved on", 8'h60, 8'h01, 16'h0000, 16'h0000, 16'd0, 0, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    std_en = 1'b0;
    run_setup("R6 std off", 8'h80, 8'h00, 16'h0000, 16'h0000, 16'd2, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    std_en = 1'b1;
    vendor_en = 1'b0;
    run_setup("R6 vendor off", 8'hC0, 8'h05, 16'h0000, 16'h0000, 16'd4, 1, 1, 2'b00, 2'b00, 0, 0, 2'b10);
    vendor_en = 1'b1;
    class_en = 1'b1;
  endtask

  task automatic t_data_stage;
    run_setup("R9 std IN", 8'h80, 8'h00, 16'h0000, 16'h0000, 16'd2, 0, 0, 2'b00, 2'b00, 1, 1, 2'b10);
    run_setup("R9 vendor OUT over IN", 8'h40, 8'h07, 16'h0000, 16'h0000, 16'd8, 0, 0, 2'b00, 2'b00, 1, 0, 2'b10);
    @(negedge clk);
    stage_done = 1'b1;
    @(negedge clk);
    stage_done = 1'b0;
    chk("R9 stage_done ends stage", 16'(stage_act), 16'd0);
    run_setup("R9 vendor IN", 8'hC0, 8'h07, 16'h0000, 16'h0000, 16'd16, 0, 0, 2'b00, 2'b00, 1, 1, 2'b10);
    run_setup("R9 next setup ends stage", 8'h21, 8'h0A, 16'h0000, 16'h0000, 16'd0, 0, 1, 2'b00, 2'b00, 0, 0, 2'b10);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    rq_type = 8'h00; rq_code = 8'd3; rq_value = '0; rq_index = '0; rq_len = '0;
    setup_vld = 1'b1;
    @(negedge clk);
    chk("R10 b2b first stall", 16'(stall_p), 16'd1);
    rq_type = 8'h21; rq_code = 8'h0A;
    @(negedge clk);
    setup_vld = 1'b0;
    chk("R10 b2b second svc", 16'(svc_p), 16'd1);
    chk("R10 b2b second no stall", 16'(stall_p), 16'd0);
    @(negedge clk);
    chk("R10 b2b idle", 16'(svc_p), 16'd0);
  endtask

  task automatic t_reset_mid;
    run_setup("R3 set ep01 again", 8'h02, 8'd3, 16'h0000, 16'h0001, 16'd0, 0, 1, 2'b01, 2'b00, 0, 0, 2'b11);
    run_setup("R9 enter stage", 8'hC0, 8'h07, 16'h0000, 16'h0000, 16'd4, 0, 0, 2'b00, 2'b00, 1, 1, 2'b11);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears halts", 16'(halt_q), 16'd0);
    chk("R11 reset ends stage", 16'(stage_act), 16'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_device_feature();
    t_halt_ops();
    t_feature_stalls();
    t_interface();
    t_routing();
    t_data_stage();
    t_back_to_back();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R10 act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule